// File: doc/BRIEF.md
# Flash Status Word Controller

This block keeps the 8-bit status word of a flash-style program/erase engine and returns it on a byte-wide read port. Commands arrive as one coded strobe per cycle. The engine itself is abstracted into a set of outcome strobes: completion, verify failure, low protection voltage, protected target, bad command sequence and paused. The block tracks whether the engine is running, waiting to pause, paused or idle. It accumulates error bits that stay set until software clears them. It also decides whether a read returns the status word or the array data supplied from outside.

A start, resume or read-status command switches the read port to status mode. A read-array command given while the engine is not running switches it back. In status mode every address returns the same status word. The value on the port is a snapshot. It is frozen for as long as both chip enable and output enable stay low. It is refreshed when either one is released and then asserted again.

Top module: `flash_status_ctrl`

## Requirements
- R1: Command codes on `cmd_op`, qualified by `cmd_vld`, are: 1 program, 2 erase, 3 block protect, 4 unprotect all, 5 suspend, 6 resume, 7 clear status, 8 read status, 9 read array; all other codes do nothing. After reset the status word is 8'h80 and the port is in array mode.
- R2: Bit 7 reads 0 from the cycle after an accepted start command (codes 1 to 4) until the engine reports completion with `eng_done`. At all other times it reads 1.
- R3: Whenever bit 7 reads 0, bits 6 to 0 read 0.
- R4: A suspend during an operation keeps bit 7 at 0 until `eng_paused` arrives. Then bit 7 and bit 6 both read 1. If `eng_done` arrives before the pause, the engine goes idle and bit 6 stays 0.
- R5: A resume while paused clears bit 6 and makes bit 7 read 0 again, until completion.
- R6: Outcome flags count only in the cycle `eng_done` is high. A verify failure sets bit 5 for an erase or an unprotect, and sets bit 4 for a program or a protect.
- R7: A low protection voltage at completion sets bit 3, and a protected target sets bit 1. Either one also sets the failure bit of the operation, as in R6.
- R8: A bad command sequence at completion sets both bit 4 and bit 5.
- R9: Bits 5, 4, 3 and 1 are sticky. They clear only on reset, or on a clear-status command given while the engine is idle or paused.
- R10: If bit 5 is set when a program or an erase starts, that operation completes as failed: a program sets bit 4, and an erase keeps bit 5.
- R11: The read port enters status mode on an accepted start, an accepted resume or a read-status command. It returns to array mode on a read-array command given while not running. In array mode a read returns `arr_data`.
- R12: The status value on the port is captured while `ce_n` or `oe_n` is high. It stays frozen while both are low.
- R13: Bits 2 and 0 always read 0. `rd_data` is 0 whenever `ce_n` or `oe_n` is high.
- R14: While running, or while waiting to pause, every command other than suspend and read status is ignored. Start commands are accepted only from idle, and a resume only while paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_vld | input | 1 | Command strobe |
| cmd_op | input | 4 | Command code |
| eng_done | input | 1 | Engine finished the current operation |
| eng_vfail | input | 1 | Verify failure, with eng_done |
| eng_vlow | input | 1 | Protection voltage low, with eng_done |
| eng_prot | input | 1 | Target block protected, with eng_done |
| eng_badseq | input | 1 | Bad command sequence, with eng_done |
| eng_paused | input | 1 | Engine reached its paused point |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| arr_data | input | 8 | Array data for array-mode reads |
| rd_data | output | 8 | Read data |
| stat_mode | output | 1 | Read port is in status mode |

## Verification
The assertions assume that the engine strobes are meaningful only relative to the block's own state. Completion and pause strobes that arrive while nothing is running must be harmless. A clear can only be seen on the cycle after it is given. The random phase deliberately sends `eng_done` and `eng_paused` in every state, and commands in every state, so that these guards are exercised rather than avoided. Directed sequences hold the chip and output enables high for one cycle before each status read, so that the snapshot includes the latest state change.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int unsigned SR_W  = 8;
    localparam int unsigned CMD_W = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP    = 4'd0,
        CMD_PROG   = 4'd1,
        CMD_ERASE  = 4'd2,
        CMD_PROT   = 4'd3,
        CMD_UNPROT = 4'd4,
        CMD_SUSP   = 4'd5,
        CMD_RESUME = 4'd6,
        CMD_CLR    = 4'd7,
        CMD_RDSTAT = 4'd8,
        CMD_RDARR  = 4'd9
    } cmd_e;

    typedef enum logic [1:0] {
        OP_PROG,
        OP_ERASE,
        OP_PROT,
        OP_UNPROT
    } op_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_RUN,
        ENG_SUSP_WAIT,
        ENG_HELD
    } eng_e;

    // sticky error flags, order matches status bits 5,4,3,1
    typedef struct packed {
        logic erase_fail;
        logic prog_fail;
        logic vlow;
        logic prot_hit;
    } sticky_t;

    typedef struct packed {
        logic done;
        logic vfail;
        logic vlow;
        logic prot;
        logic badseq;
        logic paused;
    } outcome_t;

    typedef struct packed {
        logic start;
        op_e  op;
        logic susp;
        logic resume;
        logic clr;
        logic rdstat;
        logic rdarr;
    } dec_t;

    function automatic logic is_erase_kind(op_e op);
        return (op == OP_ERASE) || (op == OP_UNPROT);
    endfunction

    function automatic op_e cmd_to_op(cmd_e c);
        op_e r;
        case (c)
            CMD_ERASE:  r = OP_ERASE;
            CMD_PROT:   r = OP_PROT;
            CMD_UNPROT: r = OP_UNPROT;
            default:    r = OP_PROG;
        endcase
        return r;
    endfunction

    function automatic sticky_t fail_bits(op_e op, outcome_t o, logic stale);
        sticky_t s;
        logic    fail;
        s    = '0;
        fail = o.vfail | o.vlow | o.prot | stale;
        if (fail) begin
            if (is_erase_kind(op)) s.erase_fail = 1'b1;
            else                   s.prog_fail  = 1'b1;
        end
        s.vlow     = o.vlow;
        s.prot_hit = o.prot;
        if (o.badseq) begin
            s.erase_fail = 1'b1;
            s.prog_fail  = 1'b1;
        end
        return s;
    endfunction

    function automatic logic [SR_W-1:0] render(eng_e st, sticky_t s);
        logic [SR_W-1:0] w;
        if (st == ENG_RUN || st == ENG_SUSP_WAIT) begin
            w = '0;
        end else begin
            w = {1'b1, (st == ENG_HELD), s.erase_fail, s.prog_fail,
                 s.vlow, 1'b0, s.prot_hit, 1'b0};
        end
        return w;
    endfunction

endpackage

// File: rtl/fsr_cmd_dec.sv
module fsr_cmd_dec
    import fsr_pkg::*;
(
    input  logic             cmd_vld,
    input  logic [CMD_W-1:0] cmd_op,
    input  eng_e             eng_st,
    output dec_t             dec
);
    cmd_e c;
    logic idle, running, held;

    assign c       = cmd_e'(cmd_op);
    assign idle    = (eng_st == ENG_IDLE);
    assign held    = (eng_st == ENG_HELD);
    assign running = (eng_st == ENG_RUN) || (eng_st == ENG_SUSP_WAIT);

    always_comb begin
        dec    = '0;
        dec.op = cmd_to_op(c);
        if (cmd_vld) begin
            case (c)
                CMD_PROG, CMD_ERASE, CMD_PROT, CMD_UNPROT: dec.start = idle;
                CMD_SUSP:   dec.susp   = (eng_st == ENG_RUN);
                CMD_RESUME: dec.resume = held;
                CMD_CLR:    dec.clr    = !running;
                CMD_RDSTAT: dec.rdstat = 1'b1;
                CMD_RDARR:  dec.rdarr  = !running;
                default:    dec        = dec;
            endcase
        end
    end
endmodule

// File: rtl/fsr_status_core.sv
module fsr_status_core
    import fsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  dec_t            dec,
    input  outcome_t        eng,
    output eng_e            eng_st,
    output sticky_t         sticky,
    output logic            busy,
    output logic            held,
    output logic [SR_W-1:0] live
);
    eng_e    st_q;
    op_e     op_q;
    logic    stale_q;
    sticky_t sticky_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ENG_IDLE;
            op_q     <= OP_PROG;
            stale_q  <= 1'b0;
            sticky_q <= '0;
        end else begin
            case (st_q)
                ENG_IDLE: begin
                    if (dec.start) begin
                        st_q    <= ENG_RUN;
                        op_q    <= dec.op;
                        stale_q <= sticky_q.erase_fail &&
                                   (dec.op == OP_PROG || dec.op == OP_ERASE);
                    end
                end
                ENG_RUN: begin
                    if (eng.done) begin
                        st_q     <= ENG_IDLE;
                        sticky_q <= sticky_q | fail_bits(op_q, eng, stale_q);
                    end else if (dec.susp) begin
                        st_q <= ENG_SUSP_WAIT;
                    end
                end
                ENG_SUSP_WAIT: begin
                    if (eng.done) begin
                        st_q     <= ENG_IDLE;
                        sticky_q <= sticky_q | fail_bits(op_q, eng, stale_q);
                    end else if (eng.paused) begin
                        st_q <= ENG_HELD;
                    end
                end
                default: begin
                    if (dec.resume) st_q <= ENG_RUN;
                end
            endcase
            if (dec.clr) sticky_q <= '0;
        end
    end

    assign eng_st = st_q;
    assign sticky = sticky_q;
    assign busy   = (st_q == ENG_RUN) || (st_q == ENG_SUSP_WAIT);
    assign held   = (st_q == ENG_HELD);
    assign live   = render(st_q, sticky_q);
endmodule

// File: rtl/fsr_read_port.sv
module fsr_read_port
    import fsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  dec_t            dec,
    input  logic [SR_W-1:0] live,
    input  logic            ce_n,
    input  logic            oe_n,
    input  logic [SR_W-1:0] arr_data,
    output logic [SR_W-1:0] rd_data,
    output logic            stat_mode
);
    localparam logic [SR_W-1:0] SNAP_RST = {1'b1, {(SR_W-1){1'b0}}};

    logic            rd_en;
    logic            mode_q;
    logic [SR_W-1:0] snap_q;

    assign rd_en = !ce_n && !oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            snap_q <= SNAP_RST;
        end else begin
            if (dec.start || dec.resume || dec.rdstat) mode_q <= 1'b1;
            else if (dec.rdarr)                        mode_q <= 1'b0;
            if (!rd_en) snap_q <= live;
        end
    end

    assign stat_mode = mode_q;
    assign rd_data   = !rd_en ? '0 : (mode_q ? snap_q : arr_data);
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
    import fsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_vld,
    input  logic [CMD_W-1:0] cmd_op,
    input  logic             eng_done,
    input  logic             eng_vfail,
    input  logic             eng_vlow,
    input  logic             eng_prot,
    input  logic             eng_badseq,
    input  logic             eng_paused,
    input  logic             ce_n,
    input  logic             oe_n,
    input  logic [SR_W-1:0]  arr_data,
    output logic [SR_W-1:0]  rd_data,
    output logic             stat_mode
);
    dec_t            dec_w;
    outcome_t        eng_w;
    eng_e            st_w;
    sticky_t         sticky_w;
    logic            busy_w;
    logic            held_w;
    logic [SR_W-1:0] live_w;

    assign eng_w = '{done: eng_done, vfail: eng_vfail, vlow: eng_vlow,
                     prot: eng_prot, badseq: eng_badseq, paused: eng_paused};

    fsr_cmd_dec dec_i (
        .cmd_vld (cmd_vld),
        .cmd_op  (cmd_op),
        .eng_st  (st_w),
        .dec     (dec_w)
    );

    fsr_status_core core_i (
        .clk    (clk),
        .rst    (rst),
        .dec    (dec_w),
        .eng    (eng_w),
        .eng_st (st_w),
        .sticky (sticky_w),
        .busy   (busy_w),
        .held   (held_w),
        .live   (live_w)
    );

    fsr_read_port port_i (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec_w),
        .live      (live_w),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .arr_data  (arr_data),
        .rd_data   (rd_data),
        .stat_mode (stat_mode)
    );
endmodule

// File: rtl/fsr_chk.sv
module fsr_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_vld,
    input logic [3:0] cmd_op,
    input logic       eng_paused,
    input logic       ce_n,
    input logic       oe_n,
    input logic [7:0] rd_data,
    input logic       stat_mode,
    input logic [3:0] sticky,
    input logic       busy,
    input logic       held
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R13
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n && stat_mode) |-> (rd_data[2] == 1'b0 && rd_data[0] == 1'b0));

    // R13
    idle_port_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |-> (rd_data == 8'h00));

    // R3
    busy_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n && stat_mode && !rd_data[7]) |-> (rd_data[6:0] == 7'h00));

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && (|($past(sticky) & ~sticky))) |-> $past(cmd_vld && cmd_op == 4'd7 && !busy));

    // R4
    held_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $rose(held)) |-> $past(eng_paused));

    // R5
    resume_chk: assert property (@(posedge clk) disable iff (rst)
        (held && cmd_vld && cmd_op == 4'd6) |=> (!held && busy));

    // R11
    auto_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_vld && cmd_op >= 4'd1 && cmd_op <= 4'd4 && !busy && !held) |=> stat_mode);
endmodule

bind flash_status_ctrl fsr_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_vld    (cmd_vld),
    .cmd_op     (cmd_op),
    .eng_paused (eng_paused),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .rd_data    (rd_data),
    .stat_mode  (stat_mode),
    .sticky     (sticky_w),
    .busy       (busy_w),
    .held       (held_w)
);

// File: tb/flash_status_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_status_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_vld = 1'b0;
    logic [3:0] cmd_op = 4'd0;
    logic       eng_done = 1'b0, eng_vfail = 1'b0, eng_vlow = 1'b0;
    logic       eng_prot = 1'b0, eng_badseq = 1'b0, eng_paused = 1'b0;
    logic       ce_n = 1'b1, oe_n = 1'b1;
    logic [7:0] arr_data = 8'h5A;
    logic [7:0] rd_data;
    logic       stat_mode;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // expectation state: 0 idle, 1 run, 2 waiting to pause, 3 paused
    int       m_st = 0;
    int       m_op = 1;
    bit       m_stale = 1'b0;
    bit [3:0] m_sticky = '0;   // {bit5, bit4, bit3, bit1}
    bit       m_mode = 1'b0;
    bit [7:0] m_snap = 8'h80;

    always #2 clk = ~clk;

    flash_status_ctrl dut_i (
        .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
        .eng_done(eng_done), .eng_vfail(eng_vfail), .eng_vlow(eng_vlow),
        .eng_prot(eng_prot), .eng_badseq(eng_badseq), .eng_paused(eng_paused),
        .ce_n(ce_n), .oe_n(oe_n), .arr_data(arr_data),
        .rd_data(rd_data), .stat_mode(stat_mode)
    );

    function automatic bit [7:0] m_live();
        if (m_st == 1 || m_st == 2) return 8'h00;
        return {1'b1, (m_st == 3), m_sticky[3], m_sticky[2], m_sticky[1], 1'b0, m_sticky[0], 1'b0};
    endfunction

    function automatic bit [7:0] m_port();
        if (ce_n || oe_n) return 8'h00;
        return m_mode ? m_snap : arr_data;
    endfunction

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic m_finish();
        bit fail;
        fail = eng_vfail || eng_vlow || eng_prot || m_stale;
        if (fail) begin
            if (m_op == 2 || m_op == 4) m_sticky[3] = 1'b1;
            else                        m_sticky[2] = 1'b1;
        end
        if (eng_vlow)   m_sticky[1] = 1'b1;
        if (eng_prot)   m_sticky[0] = 1'b1;
        if (eng_badseq) m_sticky[3:2] = 2'b11;
        m_st = 0;
    endtask

    task automatic m_step();
        bit running;
        int c;
        running = (m_st == 1 || m_st == 2);
        c = cmd_vld ? int'(cmd_op) : 0;
        if (ce_n || oe_n) m_snap = m_live();
        if ((c >= 1 && c <= 4 && m_st == 0) || (c == 6 && m_st == 3) || c == 8) m_mode = 1'b1;
        else if (c == 9 && !running) m_mode = 1'b0;
        case (m_st)
            0: if (c >= 1 && c <= 4) begin
                   m_st = 1; m_op = c;
                   m_stale = m_sticky[3] && (c == 1 || c == 2);
               end
            1: if (eng_done) m_finish(); else if (c == 5) m_st = 2;
            2: if (eng_done) m_finish(); else if (eng_paused) m_st = 3;
            default: if (c == 6) m_st = 1;
        endcase
        if (c == 7 && !running) m_sticky = '0;
    endtask

    // one cycle: inputs already set after a falling edge
    task automatic cycle();
        #1;
        chk("model R2", rd_data, m_port());
        m_step();
        @(negedge clk);
        cmd_vld = 1'b0; eng_done = 1'b0; eng_vfail = 1'b0; eng_vlow = 1'b0;
        eng_prot = 1'b0; eng_badseq = 1'b0; eng_paused = 1'b0;
    endtask

    task automatic cmd(logic [3:0] op);
        cmd_vld = 1'b1; cmd_op = op; cycle();
    endtask

    task automatic finish_op(bit vf, bit vl, bit pr, bit bs);
        eng_done = 1'b1; eng_vfail = vf; eng_vlow = vl; eng_prot = pr; eng_badseq = bs;
        cycle();
    endtask

    task automatic rd(string tag, logic [7:0] exp);
        cycle();
        ce_n = 1'b0; oe_n = 1'b0;
        cycle();
        #1;
        chk(tag, rd_data, exp);
        ce_n = 1'b1; oe_n = 1'b1;
        cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 array mode after reset
        rd("R1 array mode after reset", 8'h5A);
        cmd(4'd8);
        rd("R1 reset status", 8'h80);
        // R2 / R3 busy
        cmd(4'd1);
        rd("R2 R3 busy reads zero", 8'h00);
        finish_op(0, 0, 0, 0);
        rd("R2 ready after done", 8'h80);
        // R6 erase verify failure
        cmd(4'd2);
        finish_op(1, 0, 0, 0);
        rd("R6 erase fail bit5", 8'hA0);
        // R10 stale bit5 makes program fail
        cmd(4'd1);
        finish_op(0, 0, 0, 0);
        rd("R10 stale erase error", 8'hB0);
        cmd(4'd7);
        rd("R9 clear status", 8'h80);
        // R7 protect with low voltage and protected block
        cmd(4'd3);
        finish_op(0, 1, 1, 0);
        rd("R7 vlow and protected", 8'h9A);
        // R14 clear ignored while busy, R9 sticky across clean op
        cmd(4'd2);
        cmd(4'd7);
        finish_op(0, 0, 0, 0);
        rd("R14 clear ignored while busy", 8'h9A);
        cmd(4'd7);
        // R8 bad sequence
        cmd(4'd1);
        finish_op(0, 0, 0, 1);
        rd("R8 bad sequence", 8'hB0);
        cmd(4'd7);
        // R4 / R5 suspend and resume
        cmd(4'd2);
        cmd(4'd5);
        rd("R4 busy until paused", 8'h00);
        eng_paused = 1'b1; cycle();
        rd("R4 paused", 8'hC0);
        cmd(4'd6);
        rd("R5 resumed busy", 8'h00);
        finish_op(0, 0, 0, 0);
        rd("R5 done after resume", 8'h80);
        // R4 done before pause
        cmd(4'd1);
        cmd(4'd5);
        finish_op(0, 0, 0, 0);
        rd("R4 done before pause", 8'h80);
        // R14 read array ignored while busy, R11 accepted when idle
        cmd(4'd1);
        cmd(4'd9);
        finish_op(0, 0, 0, 0);
        rd("R14 read array ignored busy", 8'h80);
        cmd(4'd9);
        arr_data = 8'h3C;
        rd("R11 array data", 8'h3C);
        // R12 snapshot frozen while enabled
        cmd(4'd8);
        cycle();
        ce_n = 1'b0; oe_n = 1'b0;
        cmd(4'd1);
        cycle();
        #1 chk("R12 frozen snapshot", rd_data, 8'h80);
        oe_n = 1'b1; cycle();
        oe_n = 1'b0; cycle();
        #1 chk("R12 refreshed snapshot", rd_data, 8'h00);
        // R13 idle port
        oe_n = 1'b1;
        #1 chk("R13 port idle", rd_data, 8'h00);
        cycle();
        finish_op(0, 0, 0, 0);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            cmd_vld    = ($urandom_range(9, 0) < 3);
            cmd_op     = 4'($urandom_range(10, 0));
            eng_done   = ($urandom_range(9, 0) == 0);
            eng_vfail  = ($urandom_range(3, 0) == 0);
            eng_vlow   = ($urandom_range(5, 0) == 0);
            eng_prot   = ($urandom_range(5, 0) == 0);
            eng_badseq = ($urandom_range(7, 0) == 0);
            eng_paused = ($urandom_range(7, 0) == 0);
            ce_n       = 1'($urandom_range(1, 0));
            oe_n       = ($urandom_range(3, 0) == 0);
            arr_data   = 8'($urandom);
            cycle();
        end
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule